// File: doc/BRIEF.md
# Scanline and Frame Blanking Sequencer

This block derives horizontal and vertical blanking phases from one core clock. Each direction alternates between a render phase and a blank phase. The length of every phase, in clock cycles, comes from a configuration register. A phase begins on the cycle after the previous one ends, so no cycles are lost between phases. The lengths are normally computed elsewhere from the frame rate, with two blank and two render phases per frame.

Whole-line timing and half-frame timing drift apart by a rounding remainder. To absorb it, the horizontal phase in progress is stretched by a programmable correction each time the vertical sequencer goes from render to blank.

The block gives the controller the following outputs:
- level signals for horizontal and vertical blank;
- registered one-cycle pulses at the start and end of each blank;
- a frame counter;
- a sticky event status with write-one-to-clear bits;
- an interrupt output that is gated by mask bits.

Top module: `blank_seq_top`

## Requirements
- R1: While rst_n is low at a clock edge, and right after it rises, hblank and vblank are 0 (both sequencers in render), all pulses are 0, frame_cnt is 0, status is 0 and irq is 0.
- R2: The horizontal sequencer starts in render and alternates render/blank. Each phase lasts exactly the programmed number of cycles, and a length of 0 acts as 1. The first render phase after reset lasts DEF_HREN cycles.
- R3: The vertical sequencer behaves in the same way with its own two lengths, starting with a render phase of DEF_VREN cycles.
- R4: A write has cfg_we=1 and targets the register selected by cfg_addr: 0 horizontal render, 1 horizontal blank, 2 vertical render, 3 vertical blank, 4 correction, 5 control, 6 status clear. A new length is used only from the next phase of that kind, and the phase in progress keeps its length.
- R5: In the cycle where vblank rises, the horizontal phase in progress is extended by the correction value. If a horizontal boundary was due in that same cycle, it moves that many cycles later. A correction of 0 changes nothing.
- R6: The start and end pulses are registered and exactly one cycle wide. Each one is high in the first cycle of the new level of its blank signal.
- R7: Status bit 2 is set in the cycle after an hblank_end pulse if control bit 2 is 1. Status bit 3 is set in the cycle after a vblank_start pulse if control bit 3 is 1. Status bits 1:0 read 0.
- R8: Writing address 6 clears every status bit whose cfg_wdata bit is 1. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R9: irq = (status[2] and not control bit 10) or (status[3] and not control bit 11). It follows status and control combinationally.
- R10: frame_cnt increments by one, wrapping, in the cycle after each vblank_end pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | CNT_W | Configuration write data |
| hblank | output | 1 | Horizontal blank level |
| vblank | output | 1 | Vertical blank level |
| hblank_start | output | 1 | One-cycle pulse at horizontal blank start |
| hblank_end | output | 1 | One-cycle pulse at horizontal blank end |
| vblank_start | output | 1 | One-cycle pulse at vertical blank start |
| vblank_end | output | 1 | One-cycle pulse at vertical blank end |
| frame_cnt | output | FRAME_W | Count of completed vertical blanks |
| status | output | 4 | Sticky event bits (2: horizontal, 3: vertical) |
| irq | output | 1 | Interrupt from the unmasked status bits |

## Verification
Two pairs of events can land in the same cycle, and the bench provokes both.

The first pair is a vertical render-to-blank step and a horizontal boundary. The default lengths are chosen so that the first vertical render ends exactly on a horizontal blank end. The bench also counts how often the two coincide and requires this to happen at least once. The reference model handles the vertical step first and then moves the pending horizontal boundary by the correction. Any disagreement in hblank or in its pulses therefore shows up on the next compare.

The second pair is a status set and a status clear. The bench writes the clear register on every cycle for a stretch while events keep arriving, and each cycle's status must show that the set has priority.

// File: rtl/blank_seq_pkg.sv
// Package: shared register addresses and bit positions for the blanking sequencer.
package blank_seq_pkg;
    typedef enum logic [2:0] {
        A_HREN = 3'd0,
        A_HBLK = 3'd1,
        A_VREN = 3'd2,
        A_VBLK = 3'd3,
        A_CORR = 3'd4,
        A_CTRL = 3'd5,
        A_STAT = 3'd6
    } cfg_addr_e;

    localparam int ADDR_W    = 3;
    localparam int STAT_W    = 4;
    localparam int HEV_BIT   = 2;
    localparam int VEV_BIT   = 3;
    localparam int HMASK_BIT = 10;
    localparam int VMASK_BIT = 11;
endpackage

// File: rtl/blank_phase_timer.sv
// Module: blank_phase_timer
// Two-phase (render/blank) sequencer built on a remaining-cycles down counter.
// Assumes: each length is loaded when its phase starts; adj_val is added to the
// remaining count of the current phase when adj_en is high; the sum fits in REM_W.
module blank_phase_timer #(
    parameter int CNT_W    = 16,
    parameter int INIT_LEN = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] len_render,
    input  logic [CNT_W-1:0] len_blank,
    input  logic             adj_en,
    input  logic [CNT_W-1:0] adj_val,
    output logic             in_blank,
    output logic             blank_start,
    output logic             blank_end,
    output logic             enter_blank
);
    localparam int REM_W = CNT_W + 2;
    localparam logic [REM_W-1:0] ONE      = REM_W'(1);
    localparam logic [REM_W-1:0] INIT_REM = (INIT_LEN < 1) ? ONE : REM_W'(INIT_LEN);

    logic [REM_W-1:0] rem_q;
    logic [REM_W-1:0] sum;
    logic [REM_W-1:0] next_len;
    logic             boundary;

    // Remaining count after any correction, and the boundary test.
    always_comb begin
        sum      = rem_q + (adj_en ? {2'b00, adj_val} : '0);
        boundary = (sum == ONE);
    end

    // Length of the phase about to start; zero is treated as one.
    always_comb begin
        next_len = in_blank ? {2'b00, len_render} : {2'b00, len_blank};
        if (next_len == '0) next_len = ONE;
    end

    assign enter_blank = boundary && !in_blank;

    // Phase state, down counter and registered edge pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q       <= INIT_REM;
            in_blank    <= 1'b0;
            blank_start <= 1'b0;
            blank_end   <= 1'b0;
        end else begin
            blank_start <= 1'b0;
            blank_end   <= 1'b0;
            if (boundary) begin
                in_blank    <= !in_blank;
                rem_q       <= next_len;
                blank_start <= !in_blank;
                blank_end   <= in_blank;
            end else begin
                rem_q <= sum - ONE;
            end
        end
    end

    // R6
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(blank_start && blank_end));
    // R6
    start_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blank_start |-> in_blank);
    // R6
    rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_blank) |-> blank_start);
    // R2
    rem_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rem_q != '0);
endmodule

// File: rtl/blank_evt_status.sv
// Module: blank_evt_status
// Sticky event status bits with write-one-to-clear, a masked interrupt, and the frame counter.
// Assumes: event inputs are the registered one-cycle pulses from the timers.
module blank_evt_status
    import blank_seq_pkg::*;
#(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               h_end_evt,
    input  logic               v_start_evt,
    input  logic               v_end_evt,
    input  logic               hrep_en,
    input  logic               vrep_en,
    input  logic               hmask,
    input  logic               vmask,
    input  logic               clr_we,
    input  logic [1:0]         clr_bits,
    output logic [STAT_W-1:0]  status,
    output logic               irq,
    output logic [FRAME_W-1:0] frame_cnt
);
    logic h_st_q, v_st_q;

    // Sticky bits: a set has priority over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_st_q <= 1'b0;
            v_st_q <= 1'b0;
        end else begin
            h_st_q <= (h_end_evt && hrep_en) || (h_st_q && !(clr_we && clr_bits[0]));
            v_st_q <= (v_start_evt && vrep_en) || (v_st_q && !(clr_we && clr_bits[1]));
        end
    end

    // Frame counter advancing once per vertical blank end.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_cnt <= '0;
        else if (v_end_evt) frame_cnt <= frame_cnt + 1'b1;
    end

    // Status view and masked interrupt.
    always_comb begin
        status          = '0;
        status[HEV_BIT] = h_st_q;
        status[VEV_BIT] = v_st_q;
        irq             = (h_st_q && !hmask) || (v_st_q && !vmask);
    end

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status[HEV_BIT] || status[VEV_BIT]));
    // R10
    frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_cnt != $past(frame_cnt)) |-> $past(v_end_evt));
    // R7
    vset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_start_evt && vrep_en) |=> status[VEV_BIT]);
endmodule

// File: rtl/blank_seq_top.sv
// Module: blank_seq_top
// Horizontal and vertical blanking sequencer with configuration registers and event status.
// Assumes: CNT_W >= 12 so the control bits fit in cfg_wdata; lengths apply at the next boundary.
module blank_seq_top
    import blank_seq_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int FRAME_W  = 16,
    parameter int DEF_HREN = 6,
    parameter int DEF_HBLK = 5,
    parameter int DEF_VREN = 44,
    parameter int DEF_VBLK = 39,
    parameter int DEF_CORR = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [CNT_W-1:0]   cfg_wdata,
    output logic               hblank,
    output logic               vblank,
    output logic               hblank_start,
    output logic               hblank_end,
    output logic               vblank_start,
    output logic               vblank_end,
    output logic [FRAME_W-1:0] frame_cnt,
    output logic [STAT_W-1:0]  status,
    output logic               irq
);
    logic [CNT_W-1:0] hren_q, hblk_q, vren_q, vblk_q, corr_q;
    logic hrep_q, vrep_q, hmask_q, vmask_q;
    logic v_enter_blank, h_enter_unused;
    logic stat_clr_we;

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hren_q  <= CNT_W'(DEF_HREN);
            hblk_q  <= CNT_W'(DEF_HBLK);
            vren_q  <= CNT_W'(DEF_VREN);
            vblk_q  <= CNT_W'(DEF_VBLK);
            corr_q  <= CNT_W'(DEF_CORR);
            hrep_q  <= 1'b0;
            vrep_q  <= 1'b0;
            hmask_q <= 1'b0;
            vmask_q <= 1'b0;
        end else if (cfg_we) begin
            case (cfg_addr_e'(cfg_addr))
                A_HREN: hren_q <= cfg_wdata;
                A_HBLK: hblk_q <= cfg_wdata;
                A_VREN: vren_q <= cfg_wdata;
                A_VBLK: vblk_q <= cfg_wdata;
                A_CORR: corr_q <= cfg_wdata;
                A_CTRL: begin
                    hrep_q  <= cfg_wdata[HEV_BIT];
                    vrep_q  <= cfg_wdata[VEV_BIT];
                    hmask_q <= cfg_wdata[HMASK_BIT];
                    vmask_q <= cfg_wdata[VMASK_BIT];
                end
                default: ;
            endcase
        end
    end

    assign stat_clr_we = cfg_we && (cfg_addr == ADDR_W'(A_STAT));

    // Vertical sequencer: no correction input.
    blank_phase_timer #(.CNT_W(CNT_W), .INIT_LEN(DEF_VREN)) u_vtim (
        .clk         (clk),
        .rst_n       (rst_n),
        .len_render  (vren_q),
        .len_blank   (vblk_q),
        .adj_en      (1'b0),
        .adj_val     ('0),
        .in_blank    (vblank),
        .blank_start (vblank_start),
        .blank_end   (vblank_end),
        .enter_blank (v_enter_blank)
    );

    // Horizontal sequencer: stretched by the correction on vertical render-to-blank.
    blank_phase_timer #(.CNT_W(CNT_W), .INIT_LEN(DEF_HREN)) u_htim (
        .clk         (clk),
        .rst_n       (rst_n),
        .len_render  (hren_q),
        .len_blank   (hblk_q),
        .adj_en      (v_enter_blank),
        .adj_val     (corr_q),
        .in_blank    (hblank),
        .blank_start (hblank_start),
        .blank_end   (hblank_end),
        .enter_blank (h_enter_unused)
    );

    // Event status, interrupt and frame counter.
    blank_evt_status #(.FRAME_W(FRAME_W)) u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .h_end_evt   (hblank_end),
        .v_start_evt (vblank_start),
        .v_end_evt   (vblank_end),
        .hrep_en     (hrep_q),
        .vrep_en     (vrep_q),
        .hmask       (hmask_q),
        .vmask       (vmask_q),
        .clr_we      (stat_clr_we),
        .clr_bits    (cfg_wdata[VEV_BIT:HEV_BIT]),
        .status      (status),
        .irq         (irq),
        .frame_cnt   (frame_cnt)
    );

    // R3
    vstart_coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_start |-> $past(v_enter_blank));
endmodule

// File: tb/blank_seq_top_tb.sv
// Bench: absolute-time behavioural model of both sequencers, compared at every negedge.
module blank_seq_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HR0 = 6, HB0 = 5, VR0 = 44, VB0 = 39, CR0 = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic hblank, vblank, hblank_start, hblank_end, vblank_start, vblank_end, irq;
    logic [15:0] frame_cnt;
    logic [3:0]  status;

    int n_checks = 0, n_fail = 0, n_coinc = 0;
    bit done = 0;

    // model state
    int k, h_next, v_next;
    int lhr, lhb, lvr, lvb, lcorr;
    bit c_hrep, c_vrep, c_hm, c_vm;
    bit m_h, m_v, m_hs, m_he, m_vs, m_ve;
    bit st2, st3;
    int m_frame;

    blank_seq_top u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .hblank(hblank), .vblank(vblank), .hblank_start(hblank_start), .hblank_end(hblank_end),
        .vblank_start(vblank_start), .vblank_end(vblank_end), .frame_cnt(frame_cnt),
        .status(status), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int len1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // Reference model update on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            k = 0; h_next = HR0; v_next = VR0;
            lhr = HR0; lhb = HB0; lvr = VR0; lvb = VB0; lcorr = CR0;
            {c_hrep, c_vrep, c_hm, c_vm} = '0;
            {m_h, m_v, m_hs, m_he, m_vs, m_ve, st2, st3} = '0;
            m_frame = 0;
        end else begin
            bit s2, s3;
            k++;
            s2 = m_he && c_hrep;
            s3 = m_vs && c_vrep;
            if (cfg_we && cfg_addr == 3'd6) begin
                if (cfg_wdata[2]) st2 = 0;
                if (cfg_wdata[3]) st3 = 0;
            end
            st2 = st2 | s2;
            st3 = st3 | s3;
            if (m_ve) m_frame = (m_frame + 1) % 65536;
            {m_hs, m_he, m_vs, m_ve} = '0;
            if (k == v_next) begin
                if (!m_v) begin
                    m_vs = 1;
                    if (h_next == k && lcorr > 0) n_coinc++;
                    h_next += lcorr;
                    m_v = 1; v_next = k + len1(lvb);
                end else begin
                    m_ve = 1; m_v = 0; v_next = k + len1(lvr);
                end
            end
            if (k == h_next) begin
                if (!m_h) begin m_hs = 1; m_h = 1; h_next = k + len1(lhb); end
                else begin m_he = 1; m_h = 0; h_next = k + len1(lhr); end
            end
            if (cfg_we) begin
                case (cfg_addr)
                    3'd0: lhr = cfg_wdata;
                    3'd1: lhb = cfg_wdata;
                    3'd2: lvr = cfg_wdata;
                    3'd3: lvb = cfg_wdata;
                    3'd4: lcorr = cfg_wdata;
                    3'd5: begin c_hrep = cfg_wdata[2]; c_vrep = cfg_wdata[3];
                                c_hm = cfg_wdata[10]; c_vm = cfg_wdata[11]; end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, k, act, exp);
        end
    endtask

    // Compare all outputs away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                chk("R1 reset levels", {hblank, vblank}, 0);
                chk("R1 reset pulses", {hblank_start, hblank_end, vblank_start, vblank_end}, 0);
                chk("R1 reset frame/status/irq", {frame_cnt, status, irq}, 0);
            end else begin
                chk("R2/R4/R5 hblank", hblank, m_h);
                chk("R6 hblank_start", hblank_start, m_hs);
                chk("R6 hblank_end", hblank_end, m_he);
                chk("R3/R4 vblank", vblank, m_v);
                chk("R6 vblank_start", vblank_start, m_vs);
                chk("R6 vblank_end", vblank_end, m_ve);
                chk("R10 frame_cnt", frame_cnt, m_frame);
                chk("R7/R8 status", status, {st3, st2, 2'b00});
                chk("R9 irq", irq, (st2 && !c_hm) || (st3 && !c_vm));
            end
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = 3'(a); cfg_wdata = 16'(d);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(4);                   // R1 reset state
        @(negedge clk) rst_n = 1;
        wr(5, 'h00C);              // R7 reporting on, masks clear
        idle(250);                 // R5 coincidence at first vertical step
        wr(6, 'h00C);              // R8 clear both
        idle(60);
        wr(5, 'hC0C);              // R9 both masked
        idle(120);
        wr(5, 'h80C);              // R9 only vertical masked
        idle(120);
        wr(0, 3);                  // R4 mid-phase length changes
        wr(1, 2);
        idle(200);
        wr(4, 0);                  // R5 zero correction
        idle(200);
        wr(4, 7);
        wr(2, 20);                 // R3 new vertical lengths
        wr(3, 15);
        idle(200);
        wr(1, 0);                  // R2 zero length acts as one
        idle(80);
        for (int i = 0; i < 60; i++) begin   // R8 set versus clear in same cycle
            @(negedge clk);
            cfg_we = 1; cfg_addr = 3'd6; cfg_wdata = 16'h000C;
        end
        @(negedge clk) cfg_we = 0;
        wr(5, 'h000);
        wr(0, 6); wr(1, 5);
        idle(300);
        n_checks++;
        if (n_coinc == 0) begin
            n_fail++;
            $display("FAIL R5 coincidence never provoked: actual %0d expected >0", n_coinc);
        end
        finish_run();
    end
endmodule